// File: doc/BRIEF.md
# Small-Sector Write-Back Erase Buffer

This block lets a host treat a flash whose erase unit is 4096 bytes as an array of 512-byte sectors. One whole erase sector is held in a local buffer together with a tag (the erase sector number, which is the 512-byte sector number shifted right by three) and three flags: valid, dirty and erased. The host asks for a read, a write or an erase of one or more consecutive 512-byte sectors. The block loads the erase sector that holds each one, erases the backing flash sector at most once while that flag is set, and writes the whole buffer back as page programs. Write-back happens when a different erase sector has to be loaded, at the end of every write or erase request, or when the host pulses the flush input.

Data moves as 32-bit words. A 512-byte slice is 128 words and the buffer is 1024 words. The slice of sector `s` starts at buffer word `(s & 7) * 128`. Downstream the block drives a flash command engine with one-cycle requests: read a whole erase sector, erase a sector, or program one 256-byte page. The engine streams read words with `fl_rd_valid`, takes program words with `fl_wr_take`, and ends every command with a one-cycle `fl_done`.

The controller has nine states. IDLE accepts a request (priority) or a flush. LOOKUP decides between hit and miss. PROG_ISSUE/PROG_WAIT write pages back. LOAD_ISSUE/LOAD_WAIT fill the buffer. ERASE_ISSUE/ERASE_WAIT erase the backing sector. XFER moves one slice. The transitions are as follows. IDLE goes to LOOKUP on a request, and to PROG_ISSUE on a flush while dirty or erased. LOOKUP goes to XFER on a hit that is a read or that finds erased set, and to ERASE_ISSUE on any other hit. On a miss, LOOKUP goes to PROG_ISSUE if dirty or erased, otherwise to LOAD_ISSUE. PROG_WAIT goes back to PROG_ISSUE after each page except the last. After the last page it goes to LOAD_ISSUE for a miss, otherwise to IDLE. LOAD_WAIT goes to LOOKUP and ERASE_WAIT goes to XFER. XFER goes to LOOKUP for the next sector. After the last sector it goes to PROG_ISSUE for a write or an erase, and to IDLE for a read.

Top module: `slice_wb_cache`

## Requirements
- R1: The buffer tag is the sector number shifted right by 3. Sectors whose numbers differ only in the low 3 bits hit the same buffer contents, and a load reads from byte address `tag * 4096`.
- R2: After reset, `busy`, `fl_req`, `rd_valid` and `wr_rdy` are low, and the buffer is not valid, so the first access loads from flash.
- R3: On a miss, the buffer is first written back if dirty or erased is set, and then one read command (code 0) for the whole 4096-byte erase sector is issued. A miss on a clean buffer issues no page program.
- R4: A write-back issues 16 page programs (code 2) at ascending addresses `tag*4096 + 256*k`, k = 0..15, covering the whole buffer, and then clears dirty and erased. A flush pulse while neither flag is set issues no command and leaves `busy` low.
- R5: A write or erase of a slice issues a sector erase (code 1) only if the erased flag is clear, and then sets it. Several slices of one erase sector within one request cause a single erase.
- R6: An erase request (op code 2) sets every word of the selected slice to 32'hFFFFFFFF and marks the buffer dirty. It does not program flash before the closing write-back.
- R7: Every write (op 1) or erase request ends with a write-back of the buffer, so flash afterwards holds the host's view of the whole erase sector. A read request (op 0) ends without one.
- R8: The slice for sector `s` occupies buffer words `(s & 7)*128` to `(s & 7)*128 + 127`. Read words leave in ascending order on `rd_data`, one per cycle with `rd_valid`. Write words are taken in ascending order, one per cycle with `wr_rdy`.
- R9: A read that hits the buffer returns its words with no flash command.
- R10: `busy` rises the cycle after a request is accepted and stays high until the request has finished. Requests are accepted only while `busy` is low, and no flash command or data strobe occurs while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 0 read, 1 write, 2 erase |
| req_sector | input | 16 | First 512-byte sector number |
| req_count | input | 8 | Number of consecutive sectors (0 ignored) |
| flush_req | input | 1 | Force write-back when idle |
| busy | output | 1 | Request or write-back in progress |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | 32 | Read word |
| wr_rdy | output | 1 | Write word on wr_data is taken this cycle |
| wr_data | input | 32 | Write word |
| fl_req | output | 1 | One-cycle flash command strobe |
| fl_cmd | output | 2 | 0 sector read, 1 sector erase, 2 page program |
| fl_addr | output | 25 | Flash byte address of the command |
| fl_done | input | 1 | Flash command finished |
| fl_rd_valid | input | 1 | Read word from flash valid |
| fl_rd_data | input | 32 | Read word from flash |
| fl_wr_take | input | 1 | Flash engine takes fl_wr_data this cycle |
| fl_wr_data | output | 32 | Program word to flash |

## Verification
The bench exercises the block with several request patterns. A cold read separates a load from a hit. A second read in the same group of eight shows that no flash access follows a hit. A single-slice write on a hit isolates the erase-once rule and the closing write-back. A two-slice write inside one fresh erase sector shows that the erase is issued once per request. A two-slice write that crosses an erase-sector boundary forces a dirty eviction before the next load. An erase request checks the all-ones fill against the untouched neighbours in the programmed flash image. A clean flush and a clean miss confirm that nothing is written back without cause. Every read word and every flash word is compared with a behavioural model of the host-visible storage.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        HOP_READ  = 2'd0,
        HOP_WRITE = 2'd1,
        HOP_ERASE = 2'd2
    } host_op_e;

    typedef enum logic [1:0] {
        FOP_READ  = 2'd0,
        FOP_ERASE = 2'd1,
        FOP_PROG  = 2'd2
    } flash_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LOOKUP, S_PROG_ISSUE, S_PROG_WAIT,
        S_LOAD_ISSUE, S_LOAD_WAIT, S_ERASE_ISSUE, S_ERASE_WAIT, S_XFER
    } ctl_state_e;
endpackage

// File: rtl/swc_buf_ram.sv
module swc_buf_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/swc_flags.sv
module swc_flags #(
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_set,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             erase_set,
    input  logic             dirty_set,
    input  logic             wb_clr,
    output logic             valid,
    output logic             dirty,
    output logic             erased,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            dirty  <= 1'b0;
            erased <= 1'b0;
            tag    <= '0;
        end else if (load_set) begin
            valid  <= 1'b1;
            dirty  <= 1'b0;
            erased <= 1'b0;
            tag    <= load_tag;
        end else begin
            if (wb_clr) begin
                dirty  <= 1'b0;
                erased <= 1'b0;
            end
            if (erase_set) erased <= 1'b1;
            if (dirty_set) dirty  <= 1'b1;
        end
    end
endmodule

// File: rtl/slice_wb_cache.sv
module slice_wb_cache
    import swc_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SLICE_BYTES = 512,
    parameter int ERASE_BYTES = 4096,
    parameter int PAGE_BYTES  = 256,
    parameter int SEC_W       = 16,
    parameter int CNT_W       = 8,
    localparam int AW = SEC_W - $clog2(ERASE_BYTES / SLICE_BYTES) + $clog2(ERASE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [SEC_W-1:0] req_sector,
    input  logic [CNT_W-1:0] req_count,
    input  logic             flush_req,
    output logic             busy,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             wr_rdy,
    input  logic [DW-1:0]    wr_data,
    output logic             fl_req,
    output logic [1:0]       fl_cmd,
    output logic [AW-1:0]    fl_addr,
    input  logic             fl_done,
    input  logic             fl_rd_valid,
    input  logic [DW-1:0]    fl_rd_data,
    input  logic             fl_wr_take,
    output logic [DW-1:0]    fl_wr_data
);
    localparam int WB       = DW / 8;
    localparam int SLICE_W  = SLICE_BYTES / WB;
    localparam int ERASE_W  = ERASE_BYTES / WB;
    localparam int PAGES    = ERASE_BYTES / PAGE_BYTES;
    localparam int SL_SH    = $clog2(ERASE_BYTES / SLICE_BYTES);
    localparam int TAG_W    = SEC_W - SL_SH;
    localparam int IDX_W    = $clog2(ERASE_W);
    localparam int WRD_W    = $clog2(SLICE_W);
    localparam int PG_W     = $clog2(PAGES);
    localparam int ERASE_SH = $clog2(ERASE_BYTES);
    localparam int PAGE_SH  = $clog2(PAGE_BYTES);

    ctl_state_e       state, nxt;
    host_op_e         op_q;
    logic [SEC_W-1:0] sec_q;
    logic [CNT_W-1:0] left_q;
    logic [WRD_W-1:0] word_q;
    logic [IDX_W-1:0] idx_q;
    logic [PG_W-1:0]  pg_q;
    logic             reload_q;

    logic             c_valid, c_dirty, c_erased;
    logic [TAG_W-1:0] c_tag, sec_tag;
    logic             hit, need_wb, last_page, slice_end;
    logic [IDX_W-1:0] slice_addr;

    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0]    ram_wdata, ram_rdata;
    logic             load_set, erase_set, dirty_set, wb_clr;
    logic [TAG_W-1:0] addr_tag;
    logic             is_prog;

    assign sec_tag    = sec_q[SEC_W-1:SL_SH];
    assign hit        = c_valid && (c_tag == sec_tag);
    assign need_wb    = c_dirty || c_erased;
    assign last_page  = (pg_q == PG_W'(PAGES - 1));
    assign slice_end  = (word_q == WRD_W'(SLICE_W - 1));
    assign slice_addr = {sec_q[SL_SH-1:0], word_q};

    swc_flags #(.TAG_W(TAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .load_set(load_set), .load_tag(sec_tag),
        .erase_set(erase_set), .dirty_set(dirty_set), .wb_clr(wb_clr),
        .valid(c_valid), .dirty(c_dirty), .erased(c_erased), .tag(c_tag)
    );

    swc_buf_ram #(.DW(DW), .DEPTH(ERASE_W)) u_buf (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid && (req_count != '0)) nxt = S_LOOKUP;
                else if (flush_req && need_wb)      nxt = S_PROG_ISSUE;
            end
            S_LOOKUP: begin
                if (hit) nxt = (op_q == HOP_READ || c_erased) ? S_XFER : S_ERASE_ISSUE;
                else     nxt = need_wb ? S_PROG_ISSUE : S_LOAD_ISSUE;
            end
            S_PROG_ISSUE: nxt = S_PROG_WAIT;
            S_PROG_WAIT: begin
                if (fl_done) begin
                    if (!last_page)    nxt = S_PROG_ISSUE;
                    else if (reload_q) nxt = S_LOAD_ISSUE;
                    else               nxt = S_IDLE;
                end
            end
            S_LOAD_ISSUE:  nxt = S_LOAD_WAIT;
            S_LOAD_WAIT:   if (fl_done) nxt = S_LOOKUP;
            S_ERASE_ISSUE: nxt = S_ERASE_WAIT;
            S_ERASE_WAIT:  if (fl_done) nxt = S_XFER;
            S_XFER: begin
                if (slice_end) begin
                    if (left_q != CNT_W'(1))  nxt = S_LOOKUP;
                    else if (op_q != HOP_READ) nxt = S_PROG_ISSUE;
                    else                       nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        busy      = (state != S_IDLE);
        is_prog   = (state == S_PROG_ISSUE) || (state == S_PROG_WAIT);
        fl_req    = (state == S_PROG_ISSUE) || (state == S_LOAD_ISSUE) ||
                    (state == S_ERASE_ISSUE);
        fl_cmd    = is_prog ? FOP_PROG :
                    ((state == S_ERASE_ISSUE) ? FOP_ERASE : FOP_READ);
        addr_tag  = is_prog ? c_tag : sec_tag;
        fl_addr   = {addr_tag, {ERASE_SH{1'b0}}} |
                    (is_prog ? (AW'(pg_q) << PAGE_SH) : '0);
        rd_valid  = (state == S_XFER) && (op_q == HOP_READ);
        wr_rdy    = (state == S_XFER) && (op_q == HOP_WRITE);
        ram_we    = ((state == S_LOAD_WAIT) && fl_rd_valid) ||
                    ((state == S_XFER) && (op_q != HOP_READ));
        ram_waddr = (state == S_LOAD_WAIT) ? idx_q : slice_addr;
        ram_wdata = (state == S_LOAD_WAIT) ? fl_rd_data :
                    ((op_q == HOP_WRITE) ? wr_data : '1);
        ram_raddr = (state == S_PROG_WAIT) ? idx_q : slice_addr;
        rd_data    = ram_rdata;
        fl_wr_data = ram_rdata;
        load_set  = (state == S_LOAD_WAIT) && fl_done;
        erase_set = (state == S_ERASE_WAIT) && fl_done;
        dirty_set = (state == S_XFER) && slice_end && (op_q != HOP_READ);
        wb_clr    = (state == S_PROG_WAIT) && fl_done && last_page;
    end

    // request and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= HOP_READ;
            sec_q    <= '0;
            left_q   <= '0;
            word_q   <= '0;
            idx_q    <= '0;
            pg_q     <= '0;
            reload_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid && (req_count != '0)) begin
                        op_q   <= host_op_e'(req_op);
                        sec_q  <= req_sector;
                        left_q <= req_count;
                        word_q <= '0;
                    end else if (flush_req) begin
                        idx_q    <= '0;
                        pg_q     <= '0;
                        reload_q <= 1'b0;
                    end
                end
                S_LOOKUP: begin
                    if (!hit) begin
                        idx_q    <= '0;
                        pg_q     <= '0;
                        reload_q <= 1'b1;
                    end
                end
                S_PROG_WAIT: begin
                    if (fl_wr_take) idx_q <= idx_q + 1'b1;
                    if (fl_done) begin
                        pg_q <= pg_q + 1'b1;
                        if (last_page) idx_q <= '0;
                    end
                end
                S_LOAD_WAIT: if (fl_rd_valid) idx_q <= idx_q + 1'b1;
                S_XFER: begin
                    word_q <= word_q + 1'b1;
                    if (slice_end) begin
                        left_q   <= left_q - 1'b1;
                        sec_q    <= sec_q + 1'b1;
                        idx_q    <= '0;
                        pg_q     <= '0;
                        reload_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/slice_wb_cache_chk.sv
module slice_wb_cache_chk #(
    parameter int AW       = 25,
    parameter int PAGE_SH  = 8,
    parameter int ERASE_SH = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          fl_req,
    input logic [1:0]    fl_cmd,
    input logic [AW-1:0] fl_addr,
    input logic          rd_valid,
    input logic          wr_rdy
);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_req && !rd_valid && !wr_rdy));

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |=> !fl_req);

    // R4
    prog_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_cmd == 2'd2) |-> (fl_addr[PAGE_SH-1:0] == '0));

    // R1
    sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_cmd != 2'd2) |-> (fl_addr[ERASE_SH-1:0] == '0));

    // R8
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_rdy}));

    // R5
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (fl_cmd != 2'd3));
endmodule

bind slice_wb_cache slice_wb_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fl_req(fl_req), .fl_cmd(fl_cmd),
    .fl_addr(fl_addr), .rd_valid(rd_valid), .wr_rdy(wr_rdy)
);

// File: tb/slice_wb_cache_tb_top.sv
module slice_wb_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_sector = '0;
    logic [7:0]  req_count = '0;
    logic        flush_req = 1'b0;
    logic        busy, rd_valid, wr_rdy, fl_req;
    logic [31:0] rd_data, fl_wr_data;
    logic [31:0] wr_data = '0;
    logic [1:0]  fl_cmd;
    logic [24:0] fl_addr;
    logic        fl_done = 1'b0, fl_rd_valid = 1'b0, fl_wr_take = 1'b0;
    logic [31:0] fl_rd_data = '0;

    always #4 clk = ~clk;

    slice_wb_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sector(req_sector), .req_count(req_count), .flush_req(flush_req),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .wr_rdy(wr_rdy),
        .wr_data(wr_data), .fl_req(fl_req), .fl_cmd(fl_cmd), .fl_addr(fl_addr),
        .fl_done(fl_done), .fl_rd_valid(fl_rd_valid), .fl_rd_data(fl_rd_data),
        .fl_wr_take(fl_wr_take), .fl_wr_data(fl_wr_data)
    );

    int errs = 0, checks = 0;
    bit fin = 0;
    int n_rd, n_er, n_pg, last_rd_addr;
    int pg_log[$];
    int rd_ptr, wr_ptr;
    logic [31:0] wr_seed;
    logic [31:0] fl_mem  [int];
    logic [31:0] exp_mem [int];

    function automatic logic [31:0] patt(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction
    function automatic logic [31:0] fl_w(int a);
        return fl_mem.exists(a) ? fl_mem[a] : patt(a);
    endfunction
    function automatic logic [31:0] exp_w(int a);
        return exp_mem.exists(a) ? exp_mem[a] : patt(a);
    endfunction

    task automatic chk(string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    // behavioural flash command engine
    initial begin
        int base;
        forever begin
            @(negedge clk);
            fl_done = 1'b0;
            if (fl_req) begin
                base = int'(fl_addr) / 4;
                case (fl_cmd)
                    2'd0: begin
                        n_rd++;
                        last_rd_addr = int'(fl_addr);
                        for (int i = 0; i < 1024; i++) begin
                            @(negedge clk);
                            fl_rd_valid = 1'b1;
                            fl_rd_data  = fl_w(base + i);
                        end
                        @(negedge clk);
                        fl_rd_valid = 1'b0;
                        fl_done = 1'b1;
                    end
                    2'd1: begin
                        n_er++;
                        repeat (2) @(negedge clk);
                        for (int i = 0; i < 1024; i++) fl_mem[base + i] = 32'hFFFF_FFFF;
                        fl_done = 1'b1;
                    end
                    default: begin
                        n_pg++;
                        pg_log.push_back(int'(fl_addr));
                        for (int i = 0; i < 64; i++) begin
                            @(negedge clk);
                            fl_wr_take = 1'b1;
                            fl_mem[base + i] = fl_wr_data;
                        end
                        @(negedge clk);
                        fl_wr_take = 1'b0;
                        fl_done = 1'b1;
                    end
                endcase
            end
        end
    end

    // host side: per-clock comparison of read words, supply of write words
    always @(negedge clk) begin
        if (rd_valid) begin
            chk("R8 read word", rd_data, exp_w(rd_ptr));
            rd_ptr++;
        end
        if (wr_rdy) begin
            wr_data = (32'(wr_ptr) * 32'h0100_0193) ^ wr_seed;
            exp_mem[wr_ptr] = wr_data;
            wr_ptr++;
        end
    end

    task automatic run(input logic [1:0] op, input int sec, input int cnt, input logic [31:0] seed);
        n_rd = 0; n_er = 0; n_pg = 0;
        pg_log.delete();
        rd_ptr = sec * 128; wr_ptr = sec * 128; wr_seed = seed;
        if (op == 2'd2)
            for (int w = 0; w < cnt * 128; w++) exp_mem[sec * 128 + w] = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sector = 16'(sec); req_count = 8'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", busy, 1);
        while (busy) @(negedge clk);
    endtask

    task automatic check_esec(string what, int tag);
        int bad = 0;
        for (int i = 0; i < 1024; i++)
            if (fl_w(tag * 1024 + i) !== exp_w(tag * 1024 + i)) bad++;
        chk(what, bad, 0);
    endtask

    task automatic check_pages(string what, int tag);
        int bad = (pg_log.size() == 16) ? 0 : 1;
        for (int k = 0; k < pg_log.size() && k < 16; k++)
            if (pg_log[k] != tag * 4096 + 256 * k) bad++;
        chk(what, bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 busy", busy, 0);
        chk("R2 fl_req", fl_req, 0);
        chk("R2 rd_valid/wr_rdy", {rd_valid, wr_rdy}, 0);

        // cold read: R2 / R3 load, R1 address
        run(2'd0, 3, 1, 0);
        chk("R3 cold read loads", n_rd, 1);
        chk("R7 read ends without write-back", n_pg, 0);
        chk("R1 load address", last_rd_addr, 0);

        // read hit in same group of eight: R9, R1
        run(2'd0, 5, 2, 0);
        chk("R9 hit no flash command", n_rd + n_er + n_pg, 0);
        chk("R8 hit word count", rd_ptr, 7 * 128);

        // single write on a hit: R5, R4, R7
        run(2'd1, 2, 1, 32'hC0DE_0001);
        chk("R5 erase once", n_er, 1);
        chk("R9 write hit no load", n_rd, 0);
        chk("R4 page programs", n_pg, 16);
        check_pages("R4 page order", 0);
        check_esec("R7 flash image sector 0", 0);

        // two slices, same erase sector, clean miss: R3, R5
        run(2'd1, 9, 2, 32'hBEEF_0002);
        chk("R3 clean miss one load", n_rd, 1);
        chk("R1 load address tag 1", last_rd_addr, 4096);
        chk("R5 one erase for two slices", n_er, 1);
        chk("R3 clean miss no extra write-back", n_pg, 16);
        check_esec("R8 flash image sector 1", 1);

        // erase request: R6
        run(2'd2, 20, 1, 0);
        chk("R6 erase request erases once", n_er, 1);
        chk("R6 closing write-back", n_pg, 16);
        check_esec("R6 flash image sector 2", 2);

        // crossing an erase boundary: R3 dirty eviction
        run(2'd1, 15, 2, 32'h1357_0003);
        chk("R3 two loads", n_rd, 2);
        chk("R5 two erases", n_er, 2);
        chk("R3 eviction plus final write-back", n_pg, 32);
        check_esec("R3 flash image sector 1 after eviction", 1);
        check_esec("R7 flash image sector 2", 2);

        // clean flush: R4
        n_rd = 0; n_er = 0; n_pg = 0;
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        chk("R4 clean flush busy", busy, 0);
        repeat (5) @(negedge clk);
        chk("R4 clean flush no command", n_rd + n_er + n_pg, 0);

        // read back through the buffer: R9
        run(2'd0, 16, 2, 0);
        chk("R9 read after write hit", n_rd + n_er + n_pg, 0);

        // clean miss on read: R3
        run(2'd0, 40, 1, 0);
        chk("R3 read miss load", n_rd, 1);
        chk("R3 read miss no program", n_pg, 0);
        chk("R1 load address tag 5", last_rd_addr, 5 * 4096);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            errs++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule